// File: doc/BRIEF.md
# Dual-Issue In-Order Scoreboard Issuer

This block sits at the scheduling stage of a two-wide in-order pipeline. Each cycle the decode stage presents up to two instructions in two slots. Slot 0 holds the older instruction and slot 1 the younger. For each instruction the block sees its source registers, its destination register and a fixed result latency. It then decides whether none, one or both of them start execution in this cycle. The decode stage reads the per-slot stall outputs to learn which instructions it must present again.

Read-after-write hazards are resolved with a register scoreboard that keeps one down-counter per architectural register. An issuing producer loads its latency into the counter for its destination, and the counter then counts down by one each cycle. A source register is usable once its counter reaches zero. Results are written back only at the end of the execute pipeline, in program order, so write-after-read hazards cannot occur and are not checked. A flush stops issue and clears every pending prediction.

Top module: `dis_issuer`

## Requirements
- R1: After reset every register counter is zero, so a valid slot-0 instruction that reads any register issues in the first cycle it is presented.
- R2: Slot 1 issues only in a cycle in which slot 0 also issues. A stalled or empty slot 0 blocks slot 1 even when slot 1 has no hazard.
- R3: An instruction whose enabled source register has a nonzero counter does not issue. A source whose enable bit is 0 (bit 0 enables source A, bit 1 enables source B) is ignored.
- R4: A producer with latency L (0 to 2^LAT_W-1) that issues in cycle t makes its destination readable from cycle t+1+L onward. A consumer presented in cycles t+1 to t+L stalls.
- R5: When slot 0 issues and writes register d, a slot-1 instruction that reads d in an enabled source stalls in that cycle.
- R6: When both slots issue and write the same register, the counter takes the latency of slot 1.
- R7: In a cycle with flush high nothing issues, and from the next cycle all counters are zero.
- R8: stall_o[i] is high exactly when slot i is valid and does not issue. An invalid slot never issues and never stalls.
- R9: An issued instruction with its destination enable at 0 leaves the scoreboard unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Cancel issue this cycle and clear the scoreboard |
| slot_valid_i | input | 2 | Instruction present in slot 1 / slot 0 |
| src_a_i | input | 2 x REG_W | Source A register index per slot |
| src_b_i | input | 2 x REG_W | Source B register index per slot |
| src_en_i | input | 2 x 2 | Per slot: bit 0 enables source A, bit 1 enables source B |
| dst_i | input | 2 x REG_W | Destination register index per slot |
| dst_en_i | input | 2 | Per slot: instruction writes its destination |
| lat_i | input | 2 x LAT_W | Per slot: cycles until the result is readable |
| issue_o | output | 2 | Per slot: instruction issues this cycle |
| stall_o | output | 2 | Per slot: valid instruction held back |

## Verification
The bench builds the block with NREG=8 and LAT_W=3. The small register file lets the reset check read every register, including the top index, in a few cycles. The 3-bit latency allows the full sweep from 0 to 7, so the counter's largest loaded value and its back-to-back case at latency 0 are both timed cycle by cycle. Pairing, same-cycle write collisions and flush are driven as directed sequences whose stall windows follow from the latencies chosen.

// File: rtl/dis_pkg.sv
package dis_pkg;
    localparam int NUM_SLOTS = 2;

    typedef enum logic [1:0] {
        ISS_NONE = 2'd0,
        ISS_OLD  = 2'd1,
        ISS_BOTH = 2'd2
    } iss_kind_e;
endpackage

// File: rtl/dis_scoreboard.sv
module dis_scoreboard #(
    parameter int NREG  = 16,
    parameter int LAT_W = 3,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush_i,
    input  logic [1:0]                  we_i,
    input  logic [1:0][REG_W-1:0]       dst_i,
    input  logic [1:0][LAT_W-1:0]       lat_i,
    output logic [NREG-1:0]             busy_o
);
    typedef struct packed {
        logic [NREG-1:0][LAT_W-1:0] cnt;
    } sb_state_t;

    sb_state_t sb_d, sb_q;

    always_comb begin
        sb_d = sb_q;
        for (int r = 0; r < NREG; r++) begin
            if (flush_i) begin
                sb_d.cnt[r] = '0;
            end else if (we_i[1] && dst_i[1] == REG_W'(r)) begin
                sb_d.cnt[r] = lat_i[1];
            end else if (we_i[0] && dst_i[0] == REG_W'(r)) begin
                sb_d.cnt[r] = lat_i[0];
            end else if (sb_q.cnt[r] != '0) begin
                sb_d.cnt[r] = sb_q.cnt[r] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sb_q <= '0;
        end else begin
            sb_q <= sb_d;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_busy
        assign busy_o[g] = |sb_q.cnt[g];

        // R4: an untouched nonzero counter drops by exactly one
        a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
            (sb_q.cnt[g] != '0 && !flush_i
             && !(we_i[0] && dst_i[0] == REG_W'(g))
             && !(we_i[1] && dst_i[1] == REG_W'(g)))
            |=> (sb_q.cnt[g] == $past(sb_q.cnt[g]) - 1'b1));
    end

    // R7: flush empties the whole scoreboard
    a_r7_flush_clear: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (busy_o == '0));

    // R6: same-register double write keeps the younger latency
    a_r6_younger_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && we_i == 2'b11 && dst_i[0] == dst_i[1])
        |=> (sb_q.cnt[$past(dst_i[1])] == $past(lat_i[1])));
endmodule

// File: rtl/dis_issue_ctrl.sv
module dis_issue_ctrl
    import dis_pkg::*;
#(
    parameter int NREG  = 16,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic                    flush_i,
    input  logic [1:0]              slot_valid_i,
    input  logic [1:0][REG_W-1:0]   src_a_i,
    input  logic [1:0][REG_W-1:0]   src_b_i,
    input  logic [1:0][1:0]         src_en_i,
    input  logic [1:0][REG_W-1:0]   dst_i,
    input  logic [1:0]              dst_en_i,
    input  logic [NREG-1:0]         busy_i,
    output logic [1:0]              issue_o,
    output logic [1:0]              stall_o
);
    logic [NUM_SLOTS-1:0] src_ok;
    logic                 pair_hit;
    iss_kind_e            kind;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_src
        assign src_ok[s] = !(src_en_i[s][0] && busy_i[src_a_i[s]])
                        && !(src_en_i[s][1] && busy_i[src_b_i[s]]);
    end

    always_comb begin
        pair_hit = dst_en_i[0]
                && ((src_en_i[1][0] && src_a_i[1] == dst_i[0])
                 || (src_en_i[1][1] && src_b_i[1] == dst_i[0]));
        kind = ISS_NONE;
        if (!flush_i && slot_valid_i[0] && src_ok[0]) begin
            if (slot_valid_i[1] && src_ok[1] && !pair_hit) begin
                kind = ISS_BOTH;
            end else begin
                kind = ISS_OLD;
            end
        end
        issue_o[0] = (kind != ISS_NONE);
        issue_o[1] = (kind == ISS_BOTH);
        stall_o    = slot_valid_i & ~issue_o;
    end
endmodule

// File: rtl/dis_issuer.sv
module dis_issuer #(
    parameter int NREG  = 16,
    parameter int LAT_W = 3,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush_i,
    input  logic [1:0]                  slot_valid_i,
    input  logic [1:0][REG_W-1:0]       src_a_i,
    input  logic [1:0][REG_W-1:0]       src_b_i,
    input  logic [1:0][1:0]             src_en_i,
    input  logic [1:0][REG_W-1:0]       dst_i,
    input  logic [1:0]                  dst_en_i,
    input  logic [1:0][LAT_W-1:0]       lat_i,
    output logic [1:0]                  issue_o,
    output logic [1:0]                  stall_o
);
    logic [NREG-1:0] busy;
    logic [1:0]      we;

    assign we = issue_o & dst_en_i;

    dis_issue_ctrl #(.NREG(NREG)) u_ctrl (
        .flush_i      (flush_i),
        .slot_valid_i (slot_valid_i),
        .src_a_i      (src_a_i),
        .src_b_i      (src_b_i),
        .src_en_i     (src_en_i),
        .dst_i        (dst_i),
        .dst_en_i     (dst_en_i),
        .busy_i       (busy),
        .issue_o      (issue_o),
        .stall_o      (stall_o)
    );

    dis_scoreboard #(.NREG(NREG), .LAT_W(LAT_W)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush_i),
        .we_i    (we),
        .dst_i   (dst_i),
        .lat_i   (lat_i),
        .busy_o  (busy)
    );

    // R2: the younger slot never overtakes the older one
    a_r2_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o[1] |-> issue_o[0]);

    // R3: an issuing older instruction reads no pending register
    a_r3_no_raw: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o[0] |-> !((src_en_i[0][0] && busy[src_a_i[0]])
                      || (src_en_i[0][1] && busy[src_b_i[0]])));

    // R5: no same-cycle forwarding between the two slots
    a_r5_pair_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o[1] && dst_en_i[0])
        |-> !((src_en_i[1][0] && src_a_i[1] == dst_i[0])
           || (src_en_i[1][1] && src_b_i[1] == dst_i[0])));

    // R7: nothing issues under flush
    a_r7_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> (issue_o == 2'b00));

    // R8: a slot never both issues and stalls, and an empty slot does neither
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        ((issue_o & stall_o) == 2'b00) && (((issue_o | stall_o) & ~slot_valid_i) == 2'b00));
endmodule

// File: tb/dis_issuer_bench.sv
`timescale 1ns/1ps
module dis_issuer_bench;
    localparam int NREG  = 8;
    localparam int LAT_W = 3;
    localparam int REG_W = $clog2(NREG);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  flush;
    logic [1:0]            valid;
    logic [1:0][REG_W-1:0] sa, sb, dst;
    logic [1:0][1:0]       sen;
    logic [1:0]            den;
    logic [1:0][LAT_W-1:0] lat;
    logic [1:0]            issue, stall;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [1:0] iss;
        logic [1:0] stl;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    dis_issuer #(.NREG(NREG), .LAT_W(LAT_W)) u_dis_issuer (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .slot_valid_i(valid),
        .src_a_i(sa), .src_b_i(sb), .src_en_i(sen), .dst_i(dst),
        .dst_en_i(den), .lat_i(lat), .issue_o(issue), .stall_o(stall)
    );

    task automatic idle_inputs();
        flush = 1'b0; valid = '0; sa = '0; sb = '0;
        sen = '0; dst = '0; den = '0; lat = '0;
    endtask

    // advance one cycle and present a clean input set
    task automatic next_cycle();
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    task automatic expect_out(input logic [1:0] iss, input logic [1:0] stl, input string tag);
        exp_t e;
        e.iss = iss; e.stl = stl; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares in the middle of the cycle the driver filled
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (issue !== e.iss || stall !== e.stl) begin
                    errors++;
                    $display("FAIL %s: issue=%b stall=%b expected issue=%b stall=%b",
                             e.tag, issue, stall, e.iss, e.stl);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: every register readable right after reset
        for (int r = 0; r < NREG; r++) begin
            next_cycle();
            valid = 2'b01; sa[0] = REG_W'(r); sen[0] = 2'b01;
            expect_out(2'b01, 2'b00, "R1 reset ready");
        end

        // producer r3 latency 2
        next_cycle();
        valid = 2'b01; sa[0] = 1; sb[0] = 2; sen[0] = 2'b11;
        dst[0] = 3; den[0] = 1; lat[0] = 2;
        expect_out(2'b01, 2'b00, "R1 first issue");

        // R2/R3: consumer of r3 stalls, blocking an independent younger one
        for (int k = 0; k < 2; k++) begin
            next_cycle();
            valid = 2'b11; sb[0] = 3; sen[0] = 2'b10;
            sa[1] = 4; sen[1] = 2'b01;
            expect_out(2'b00, 2'b11, "R2 R3 older blocked");
        end
        // R4: readable at t+1+2
        next_cycle();
        valid = 2'b11; sb[0] = 3; sen[0] = 2'b10; dst[0] = 5; den[0] = 1; lat[0] = 0;
        sa[1] = 6; sen[1] = 2'b01; dst[1] = 6; den[1] = 1; lat[1] = 1;
        expect_out(2'b11, 2'b00, "R4 dual issue at t+1+L");

        // R5: slot 1 reads slot 0 destination
        next_cycle();
        valid = 2'b11; sa[0] = 5; sen[0] = 2'b01; dst[0] = 7; den[0] = 1; lat[0] = 4;
        sb[1] = 7; sen[1] = 2'b10;
        expect_out(2'b01, 2'b10, "R5 pair hazard");

        // R3: disabled source on a busy register is ignored; R9: no dst write
        next_cycle();
        valid = 2'b01; sa[0] = 7; sb[0] = 7; sen[0] = 2'b00;
        dst[0] = 1; den[0] = 0; lat[0] = 5;
        expect_out(2'b01, 2'b00, "R3 disabled source ignored");
        next_cycle();
        valid = 2'b01; sa[0] = 1; sen[0] = 2'b01;
        expect_out(2'b01, 2'b00, "R9 no scoreboard write");

        // R6: same destination in both slots, younger latency 1 wins
        next_cycle();
        valid = 2'b11; dst[0] = 2; den[0] = 1; lat[0] = 5;
        dst[1] = 2; den[1] = 1; lat[1] = 1;
        expect_out(2'b11, 2'b00, "R6 double write");
        next_cycle();
        valid = 2'b01; sa[0] = 2; sen[0] = 2'b01;
        expect_out(2'b00, 2'b01, "R6 one stall cycle");
        next_cycle();
        valid = 2'b01; sa[0] = 2; sen[0] = 2'b01;
        expect_out(2'b01, 2'b00, "R6 younger latency applied");

        // R7: flush
        next_cycle();
        valid = 2'b01; dst[0] = 4; den[0] = 1; lat[0] = 7;
        expect_out(2'b01, 2'b00, "R7 long producer");
        next_cycle();
        valid = 2'b01; sa[0] = 6; sen[0] = 2'b00; flush = 1;
        expect_out(2'b00, 2'b01, "R7 no issue under flush");
        next_cycle();
        valid = 2'b11; sa[0] = 4; sen[0] = 2'b01; sb[1] = 4; sen[1] = 2'b10;
        expect_out(2'b11, 2'b00, "R7 cleared after flush");

        // R8: empty older slot, then both empty
        next_cycle();
        valid = 2'b10; sa[1] = 0; sen[1] = 2'b01;
        expect_out(2'b00, 2'b10, "R8 R2 lone younger");
        next_cycle();
        expect_out(2'b00, 2'b00, "R8 idle");

        // R4: full latency sweep
        for (int l = 0; l < (1 << LAT_W); l++) begin
            next_cycle();
            valid = 2'b01; dst[0] = 5; den[0] = 1; lat[0] = LAT_W'(l);
            expect_out(2'b01, 2'b00, $sformatf("R4 producer L=%0d", l));
            for (int k = 0; k < l; k++) begin
                next_cycle();
                valid = 2'b01; sa[0] = 5; sen[0] = 2'b01;
                expect_out(2'b00, 2'b01, $sformatf("R4 wait L=%0d k=%0d", l, k));
            end
            next_cycle();
            valid = 2'b01; sa[0] = 5; sen[0] = 2'b01;
            expect_out(2'b01, 2'b00, $sformatf("R4 ready L=%0d", l));
        end

        next_cycle();
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule